// File: doc/BRIEF.md
# Reconfigurable Pixel Counter Sub-Array

This block holds the digital counting resources for a 4x4 group of imaging pixels. Thirty-two 8-bit register segments form one 256-bit store. A per-group allocation setting joins these segments into counters and assigns each counter to an owning pixel. Each owning pixel then counts the synchronous event pulses on its own input. Each pixel has a counting mode: it can count up, count down, run as a first-event timer, or stay idle. Every counter saturates and never wraps.

Readout and preload use the same store. As a serial shift register it moves one bit per clock to the left or to the right, with a serial input and a serial output at each end. As a byte-wide route it passes whole segments to a neighbouring group in the perpendicular direction. Configuration is captured while a load strobe is high, and it becomes active at the next frame reset. A frame reset also clears every counter and every timer stop flag.

Top module: `pxc_subarray`

## Requirements
- R1: After the asynchronous reset, every store bit is zero. The active allocation is 0 and every pixel mode is count-up (code 0).
- R2: Segment s occupies store bits [8s+7:8s]. Each allocation code assigns segments to pixels as follows. Code 0 gives pixel p segments 2p and 2p+1. Code 1 gives pixel 4k segments 8k to 8k+7. Code 2 gives pixel 0 all 32 segments. Code 3 gives pixel 4k segments 8k to 8k+4, and gives pixel 4k+j (j=1..3) segment 8k+4+j. In every case a carry or borrow ripples from a lower segment into the next higher one. Pixels that own no segment have no effect.
- R3: In count-up mode (code 0), a counter adds one on each clock cycle in which its owner's event bit is high.
- R4: In count-down mode (code 1), a counter subtracts one on each owner event and holds at zero.
- R5: A counting-up counter holds at all ones and never wraps.
- R6: In timer mode (code 2), a counter adds one on each counting cycle until the owner's first event after a frame reset. It does not advance in the cycle of that event, and it holds from then on. Later events have no effect. Idle mode (code 3) never changes the counter.
- R7: A frame reset clears the whole store and all timer stop flags. An event in the same cycle is discarded.
- R8: Allocation and pixel modes (2 bits per pixel, pixel p at bits [2p+1:2p]) are captured only while cfg_en_i is high. They become active only at the next frame reset.
- R9: A left shift (direction 0) moves the store up one bit per clock. ser_lo_i enters at bit 0, and bit 255 is visible on ser_hi_o.
- R10: A right shift (direction 1) moves the store down one bit per clock. ser_hi_i enters at bit 255, and bit 0 is visible on ser_lo_o.
- R11: An orthogonal route moves the store up by one segment per clock. orth_i enters at segment 0, and segment 31 is visible on orth_o.
- R12: Priority per cycle is frame reset first, then serial shift, then orthogonal route, then counting. Events arriving in shift or route cycles are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_rst_i | input | 1 | Synchronous frame reset, applies pending configuration |
| event_i | input | 16 | Per-pixel single-cycle event pulses |
| cfg_en_i | input | 1 | Configuration capture strobe |
| cfg_alloc_i | input | 2 | Pending allocation code |
| cfg_mode_i | input | 32 | Pending per-pixel counting modes |
| shift_en_i | input | 1 | Serial shift enable |
| shift_dir_i | input | 1 | Shift direction: 0 left, 1 right |
| ser_lo_i | input | 1 | Serial input at the low end |
| ser_hi_i | input | 1 | Serial input at the high end |
| ser_lo_o | output | 1 | Store bit 0 |
| ser_hi_o | output | 1 | Store bit 255 |
| orth_en_i | input | 1 | Orthogonal route enable |
| orth_i | input | 8 | Segment entering from the neighbour group |
| orth_o | output | 8 | Top segment leaving to the neighbour group |

## Verification
The assertions assume that every event pulse is synchronous and that a frame reset is sampled on a clock edge like any other data input. They also assume that configuration is never loaded in the same cycle as a frame reset. The bench drives all inputs one time unit after the rising edge. It raises cfg_en_i only in cycles without a frame reset. Random event words are applied only in counting cycles, except where a test deliberately sends events with a frame reset, shift or route to check that they are discarded.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  localparam int N_PIX  = 16;
  localparam int N_SEG  = 32;
  localparam int PIX_IW = $clog2(N_PIX);

  typedef enum logic [1:0] {ALLOC_16X16, ALLOC_4X64, ALLOC_1X256, ALLOC_MIX} alloc_e;
  typedef enum logic [1:0] {CM_UP, CM_DOWN, CM_TIMER, CM_IDLE} cmode_e;

  function automatic logic seg_head(alloc_e a, int s);
    case (a)
      ALLOC_16X16: return (s % 2) == 0;
      ALLOC_4X64:  return (s % 8) == 0;
      ALLOC_1X256: return s == 0;
      default:     return ((s % 8) == 0) || ((s % 8) >= 5);
    endcase
  endfunction

  function automatic logic [PIX_IW-1:0] seg_owner(alloc_e a, int s);
    int k, r, o;
    k = s / 8;
    r = s % 8;
    case (a)
      ALLOC_16X16: o = s / 2;
      ALLOC_4X64:  o = 4 * k;
      ALLOC_1X256: o = 0;
      default:     o = (r < 5) ? 4 * k : 4 * k + r - 4;
    endcase
    return PIX_IW'(o);
  endfunction
endpackage

// File: rtl/pxc_cfg.sv
module pxc_cfg
  import pxc_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     frame_rst_i,
  input  logic                     cfg_en_i,
  input  logic [1:0]               cfg_alloc_i,
  input  logic [2*N_PIX-1:0]       cfg_mode_i,
  output alloc_e                   alloc_o,
  output logic [N_PIX-1:0][1:0]    mode_o
);
  alloc_e                alloc_sh, alloc_q;
  logic [N_PIX-1:0][1:0] mode_sh, mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alloc_sh <= ALLOC_16X16;
      mode_sh  <= '0;
    end else if (cfg_en_i) begin
      alloc_sh <= alloc_e'(cfg_alloc_i);
      mode_sh  <= cfg_mode_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alloc_q <= ALLOC_16X16;
      mode_q  <= '0;
    end else if (frame_rst_i) begin
      alloc_q <= alloc_sh;
      mode_q  <= mode_sh;
    end
  end

  assign alloc_o = alloc_q;
  assign mode_o  = mode_q;

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_rst_i |=> ($stable(alloc_q) && $stable(mode_q)));
endmodule

// File: rtl/pxc_map.sv
module pxc_map
  import pxc_pkg::*;
(
  input  alloc_e                         alloc_i,
  output logic [N_SEG-1:0]               head_o,
  output logic [N_SEG-1:0][PIX_IW-1:0]   owner_o
);
  for (genvar s = 0; s < N_SEG; s++) begin : g_seg
    assign head_o[s]  = seg_head(alloc_i, s);
    assign owner_o[s] = seg_owner(alloc_i, s);
  end
endmodule

// File: rtl/pxc_pixel_ctl.sv
module pxc_pixel_ctl
  import pxc_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   frame_rst_i,
  input  logic                   count_cyc_i,
  input  logic [N_PIX-1:0]       event_i,
  input  logic [N_PIX-1:0][1:0]  mode_i,
  output logic [N_PIX-1:0]       req_o
);
  logic [N_PIX-1:0] stopped_q;

  for (genvar p = 0; p < N_PIX; p++) begin : g_pix
    logic is_tmr;
    assign is_tmr = (mode_i[p] == CM_TIMER);

    always_comb begin
      case (cmode_e'(mode_i[p]))
        CM_UP, CM_DOWN: req_o[p] = count_cyc_i & event_i[p];
        CM_TIMER:       req_o[p] = count_cyc_i & ~stopped_q[p] & ~event_i[p];
        default:        req_o[p] = 1'b0;
      endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              stopped_q[p] <= 1'b0;
      else if (frame_rst_i)                     stopped_q[p] <= 1'b0;
      else if (count_cyc_i && is_tmr && event_i[p]) stopped_q[p] <= 1'b1;
    end

    // R6
    stop_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stopped_q[p] && !frame_rst_i) |=> stopped_q[p]);
  end
endmodule

// File: rtl/pxc_seg_chain.sv
module pxc_seg_chain
  import pxc_pkg::*;
#(
  parameter int SEG_W = 8,
  localparam int TOT_W = SEG_W * N_SEG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_rst_i,
  input  logic              shift_en_i,
  input  logic              shift_dir_i,
  input  logic              ser_lo_i,
  input  logic              ser_hi_i,
  input  logic              orth_en_i,
  input  logic [SEG_W-1:0]  orth_i,
  input  logic [N_SEG-1:0]  head_i,
  input  logic [N_SEG-1:0]  down_i,
  input  logic [N_SEG-1:0]  req_i,
  output logic              ser_lo_o,
  output logic              ser_hi_o,
  output logic [SEG_W-1:0]  orth_o
);
  logic [TOT_W-1:0] data_q;
  logic [N_SEG-1:0] ext, all_ext, cin;
  logic             count_cyc;

  assign count_cyc = ~frame_rst_i & ~shift_en_i & ~orth_en_i;

  always_comb begin
    logic run;
    for (int s = 0; s < N_SEG; s++)
      ext[s] = down_i[s] ? (data_q[s*SEG_W +: SEG_W] == '0) : (&data_q[s*SEG_W +: SEG_W]);
    // backward: whole counter at its limit
    run = 1'b1;
    for (int s = N_SEG - 1; s >= 0; s--) begin
      if (s == N_SEG - 1 || head_i[(s + 1) % N_SEG]) run = ext[s];
      else                                            run = run & ext[s];
      all_ext[s] = run;
    end
    // forward: ripple from head segment
    run = 1'b0;
    for (int s = 0; s < N_SEG; s++) begin
      if (s == 0 || head_i[s]) run = req_i[s] & ~all_ext[s];
      else                     run = run & ext[s - 1];
      cin[s] = run;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (frame_rst_i) begin
      data_q <= '0;
    end else if (shift_en_i) begin
      if (shift_dir_i) data_q <= {ser_hi_i, data_q[TOT_W-1:1]};
      else             data_q <= {data_q[TOT_W-2:0], ser_lo_i};
    end else if (orth_en_i) begin
      data_q <= {data_q[TOT_W-SEG_W-1:0], orth_i};
    end else begin
      for (int s = 0; s < N_SEG; s++)
        if (cin[s])
          data_q[s*SEG_W +: SEG_W] <= down_i[s] ? data_q[s*SEG_W +: SEG_W] - 1'b1
                                                : data_q[s*SEG_W +: SEG_W] + 1'b1;
    end
  end

  assign ser_lo_o = data_q[0];
  assign ser_hi_o = data_q[TOT_W-1];
  assign orth_o   = data_q[TOT_W-1 -: SEG_W];

  // R7
  frame_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_rst_i |=> (data_q == '0));
  // R9
  shl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_i && !frame_rst_i && !shift_dir_i) |=>
      (data_q == {$past(data_q[TOT_W-2:0]), $past(ser_lo_i)}));
  // R10
  shr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_i && !frame_rst_i && shift_dir_i) |=>
      (data_q == {$past(ser_hi_i), $past(data_q[TOT_W-1:1])}));

  for (genvar s = 0; s < N_SEG; s++) begin : g_sat
    // R5
    sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (count_cyc && head_i[s] && all_ext[s]) |=> $stable(data_q[s*SEG_W +: SEG_W]));
  end
endmodule

// File: rtl/pxc_subarray.sv
module pxc_subarray
  import pxc_pkg::*;
#(
  parameter int SEG_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_rst_i,
  input  logic [N_PIX-1:0]   event_i,
  input  logic               cfg_en_i,
  input  logic [1:0]         cfg_alloc_i,
  input  logic [2*N_PIX-1:0] cfg_mode_i,
  input  logic               shift_en_i,
  input  logic               shift_dir_i,
  input  logic               ser_lo_i,
  input  logic               ser_hi_i,
  output logic               ser_lo_o,
  output logic               ser_hi_o,
  input  logic               orth_en_i,
  input  logic [SEG_W-1:0]   orth_i,
  output logic [SEG_W-1:0]   orth_o
);
  alloc_e                        alloc;
  logic [N_PIX-1:0][1:0]         mode;
  logic [N_SEG-1:0]              head, down, req_seg;
  logic [N_SEG-1:0][PIX_IW-1:0]  owner;
  logic [N_PIX-1:0]              req_pix;
  logic                          count_cyc;

  assign count_cyc = ~frame_rst_i & ~shift_en_i & ~orth_en_i;

  pxc_cfg u_cfg (
    .clk_i, .rst_ni, .frame_rst_i, .cfg_en_i, .cfg_alloc_i, .cfg_mode_i,
    .alloc_o(alloc), .mode_o(mode)
  );

  pxc_map u_map (.alloc_i(alloc), .head_o(head), .owner_o(owner));

  pxc_pixel_ctl u_pix (
    .clk_i, .rst_ni, .frame_rst_i, .count_cyc_i(count_cyc),
    .event_i, .mode_i(mode), .req_o(req_pix)
  );

  for (genvar s = 0; s < N_SEG; s++) begin : g_route
    assign down[s]    = (mode[owner[s]] == CM_DOWN);
    assign req_seg[s] = req_pix[owner[s]];
  end

  pxc_seg_chain #(.SEG_W(SEG_W)) u_chain (
    .clk_i, .rst_ni, .frame_rst_i, .shift_en_i, .shift_dir_i, .ser_lo_i, .ser_hi_i,
    .orth_en_i, .orth_i, .head_i(head), .down_i(down), .req_i(req_seg),
    .ser_lo_o, .ser_hi_o, .orth_o
  );
endmodule

// File: tb/sim_pxc_subarray.sv
module sim_pxc_subarray;
  localparam int TW = 256;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic frame_rst_i = 1'b0;
  logic [15:0] event_i = '0;
  logic cfg_en_i = 1'b0;
  logic [1:0] cfg_alloc_i = '0;
  logic [31:0] cfg_mode_i = '0;
  logic shift_en_i = 1'b0, shift_dir_i = 1'b0, ser_lo_i = 1'b0, ser_hi_i = 1'b0;
  logic ser_lo_o, ser_hi_o;
  logic orth_en_i = 1'b0;
  logic [7:0] orth_i = '0, orth_o;

  pxc_subarray u0 (.*);

  always #5 clk_i = ~clk_i;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [TW-1:0] exp_v, rd;
  logic [15:0] stop_m;
  logic [1:0]  sh_alloc = 0, act_alloc = 0;
  logic [31:0] sh_mode = 0, act_mode = 0;

  task automatic chk(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] ex);
    n_run++;
    if (act !== ex) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, ex);
    end
  endtask

  task automatic tick;
    @(posedge clk_i);
    #1;
  endtask

  // counter placement: first segment and length in segments
  function automatic int c_lo(logic [1:0] a, int p);
    if (a == 3 && (p % 4) != 0) return 2 * p + 4 - (p % 4);
    return 2 * p;
  endfunction
  function automatic int c_len(logic [1:0] a, int p);
    case (a)
      0: return 2;
      1: return (p % 4 == 0) ? 8 : 0;
      2: return (p == 0) ? 32 : 0;
      default: return (p % 4 == 0) ? 5 : 1;
    endcase
  endfunction

  function automatic void model_step(logic [15:0] ev);
    for (int p = 0; p < 16; p++) begin
      int len, sh;
      logic [TW-1:0] mask, v;
      logic [1:0] md;
      len = c_len(act_alloc, p);
      if (len == 0) continue;
      sh = 8 * c_lo(act_alloc, p);
      mask = (len == 32) ? '1 : ((TW'(1) << (8 * len)) - 1);
      v = (exp_v >> sh) & mask;
      md = act_mode[2*p +: 2];
      case (md)
        2'd0: if (ev[p] && v != mask) v = v + 1;
        2'd1: if (ev[p] && v != 0) v = v - 1;
        2'd2: if (!stop_m[p]) begin
                if (ev[p]) stop_m[p] = 1'b1;
                else if (v != mask) v = v + 1;
              end
        default: ;
      endcase
      exp_v = (exp_v & ~(mask << sh)) | (v << sh);
    end
  endfunction

  task automatic count(input int n, input bit rnd, input logic [15:0] fixed);
    for (int i = 0; i < n; i++) begin
      logic [15:0] ev;
      ev = rnd ? 16'($urandom) : fixed;
      event_i = ev;
      tick();
      model_step(ev);
    end
    event_i = '0;
  endtask

  task automatic frame;
    frame_rst_i = 1'b1;
    event_i = 16'hffff;  // R7: discarded
    tick();
    frame_rst_i = 1'b0;
    event_i = '0;
    exp_v = '0;
    stop_m = '0;
    act_alloc = sh_alloc;
    act_mode = sh_mode;
  endtask

  task automatic cfg(input logic [1:0] a, input logic [31:0] m);
    cfg_en_i = 1'b1;
    cfg_alloc_i = a;
    cfg_mode_i = m;
    tick();
    cfg_en_i = 1'b0;
    sh_alloc = a;
    sh_mode = m;
  endtask

  task automatic read_all;
    shift_en_i = 1'b1;
    shift_dir_i = 1'b0;
    for (int i = 0; i < TW; i++) begin
      rd[TW-1-i] = ser_hi_o;
      ser_lo_i = ser_hi_o;
      event_i = 16'($urandom);  // R12: ignored while shifting
      tick();
    end
    shift_en_i = 1'b0;
    event_i = '0;
  endtask

  task automatic load(input logic [TW-1:0] v);
    shift_en_i = 1'b1;
    shift_dir_i = 1'b0;
    for (int i = 0; i < TW; i++) begin
      ser_lo_i = v[TW-1-i];
      tick();
    end
    shift_en_i = 1'b0;
    exp_v = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    exp_v = '0;
    stop_m = '0;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    // R1 reset state
    chk("R1 orth_o", TW'(orth_o), '0);
    chk("R1 ser_hi_o", TW'(ser_hi_o), '0);
    read_all();
    chk("R1 store", rd, '0);
    count(20, 0, 16'hffff);  // default: alloc 0, all up
    read_all();
    chk("R1 default up", rd, exp_v);

    // R2 R3: each allocation with random owner events
    for (int a = 0; a < 4; a++) begin
      cfg(2'(a), 32'h0);
      frame();
      count(150, 1, '0);
      read_all();
      chk($sformatf("R2 R3 alloc %0d", a), rd, exp_v);
    end

    // R4 down with zero hold
    cfg(2'd1, 32'h5555_5555);
    frame();
    begin
      logic [TW-1:0] v;
      v = '0;
      v[0 +: 64] = 64'd3;
      v[64 +: 64] = 64'd0;
      v[128 +: 64] = 64'h1_0000_0005;
      v[192 +: 64] = 64'd40;
      load(v);
    end
    count(60, 1, '0);
    read_all();
    chk("R4 down hold", rd, exp_v);

    // R5 up saturation in mixed allocation
    cfg(2'd3, 32'h0);
    frame();
    begin
      logic [TW-1:0] v;
      v = '0;
      for (int p = 0; p < 16; p++) begin
        int len = c_len(2'd3, p);
        logic [TW-1:0] m;
        m = (TW'(1) << (8 * len)) - 1;
        v = v | ((m - 2) << (8 * c_lo(2'd3, p)));
      end
      load(v);
    end
    count(8, 0, 16'hffff);
    chk("R5 saturate", exp_v, '1);
    read_all();
    chk("R5 store", rd, '1);

    // R8 config not active until frame reset
    cfg(2'd0, 32'h0);
    count(30, 1, '0);
    read_all();
    chk("R8 pending ignored", rd, exp_v);
    cfg_alloc_i = 2'd2;  // no strobe
    cfg_mode_i = 32'hffff_ffff;
    tick();
    frame();
    count(40, 1, '0);
    read_all();
    chk("R8 no strobe", rd, exp_v);

    // R6 timer: first event stops, later events ignored; idle pixels
    cfg(2'd0, 32'hfaaa_aaaa);  // pixels 14,15 idle
    frame();
    for (int t = 0; t < 45; t++) begin
      logic [15:0] ev;
      ev = '0;
      for (int p = 0; p < 16; p++) if (t == 3 + 2 * p || t == 40) ev[p] = 1'b1;
      count(1, 0, ev);
    end
    read_all();
    chk("R6 timer", rd, exp_v);

    // R7 frame reset wins over events
    frame();
    read_all();
    chk("R7 cleared", rd, '0);

    // R10 right shift
    cfg(2'd0, 32'h0);
    frame();
    begin
      logic [TW-1:0] v;
      v = {8{32'($urandom)}};
      load(v);
      shift_en_i = 1'b1;
      shift_dir_i = 1'b1;
      for (int i = 0; i < 7; i++) begin
        logic b;
        b = 1'($urandom);
        chk("R10 ser_lo_o", TW'(ser_lo_o), TW'(exp_v[0]));
        ser_hi_i = b;
        tick();
        exp_v = {b, exp_v[TW-1:1]};
      end
      shift_en_i = 1'b0;
      shift_dir_i = 1'b0;
      read_all();
      chk("R10 right shift", rd, exp_v);
    end

    // R11 orthogonal route; R12 shift beats route
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      orth_en_i = 1'b1;
      orth_i = b;
      event_i = 16'hffff;
      tick();
      exp_v = {exp_v[TW-9:0], b};
    end
    orth_en_i = 1'b0;
    event_i = '0;
    chk("R11 orth_o", TW'(orth_o), TW'(exp_v[TW-1 -: 8]));
    orth_en_i = 1'b1;
    shift_en_i = 1'b1;
    ser_lo_i = 1'b1;
    tick();
    exp_v = {exp_v[TW-2:0], 1'b1};
    orth_en_i = 1'b0;
    shift_en_i = 1'b0;
    read_all();
    chk("R11 R12 store", rd, exp_v);

    // R12 frame reset beats shift
    frame_rst_i = 1'b1;
    shift_en_i = 1'b1;
    ser_lo_i = 1'b1;
    tick();
    frame_rst_i = 1'b0;
    shift_en_i = 1'b0;
    read_all();
    chk("R12 frame over shift", rd, '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule